// File: doc/BRIEF.md
# Serial Offset Programming Port

This block holds the two threshold values that a FIFO flag generator compares against its fill level: one offset for the almost-empty warning and one for the almost-full warning. Both values sit in a single serial chain. Software or a test controller loads the chain one bit per rising edge of the serial clock, and can shift it back out on a serial output to confirm what was loaded. The two assembled offsets are always present as parallel outputs for the flag logic.

The pins are shared with an unrelated test port. A select input hands the pins to that test port when high, and the block then ignores all serial activity. A load with the write enable low starts at the first chain bit. It continues until the enable is released, wrapping if it runs past the end of the chain. A readback always starts from the first chain bit. Releasing the read enable discards the read position, so an interrupted readback cannot be resumed.

Top module: `sop_serial_port`

## Requirements
- R1: Chain layout is fixed: chain bit i (0 to OFFSET_W-1) is bit i of `empty_ofs`, and chain bit OFFSET_W+i is bit i of `full_ofs`. A load writes `ser_in` into the chain bit at the write position on each rising `sclk` edge with `port_sel`=0 and `wr_en_n`=0, so values arrive least significant bit first, almost-empty offset first.
- R2: While `wr_en_n`=1, or while `port_sel`=1, neither `empty_ofs` nor `full_ofs` changes.
- R3: On each rising edge with `port_sel`=0, `wr_en_n`=1 and `rd_en_n`=0, `ser_out` takes the chain bit at the read position, which then advances; a readback begins at chain bit 0.
- R4: On each rising edge with `port_sel`=0 and `rd_en_n`=1, the read position returns to chain bit 0 and `ser_out` keeps its value; the next readback restarts at bit 0.
- R5: While `port_sel`=1, no bit is loaded, no bit is read, `ser_out` holds and both positions hold.
- R6: Synchronous active-low reset sets `empty_ofs` to EMPTY_DEFAULT (7), `full_ofs` to FULL_DEFAULT (7), `ser_out` to 0 and both positions to bit 0.
- R7: A load longer than 2*OFFSET_W bits wraps: the bit after the last chain bit is written into chain bit 0.
- R8: On each rising edge with `port_sel`=0 and `wr_en_n`=1, the write position returns to chain bit 0, so every load starts at bit 0.
- R9: With `wr_en_n`=0 and `rd_en_n`=0 together (and `port_sel`=0), the edge performs a load only; `ser_out` and the read position hold.
- R10: A readback longer than 2*OFFSET_W bits wraps: after the last chain bit, chain bit 0 is driven again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | 1 hands the shared pins to the test port; 0 enables serial programming |
| wr_en_n | input | 1 | Active-low serial load enable |
| rd_en_n | input | 1 | Active-low serial readback enable |
| ser_in | input | 1 | Serial load data |
| ser_out | output | 1 | Serial readback data, registered |
| empty_ofs | output | OFFSET_W | Assembled almost-empty offset |
| full_ofs | output | OFFSET_W | Assembled almost-full offset |

## Verification
Every cycle, the assertions check the hold rules (offsets frozen outside a load, output and positions frozen while the test port owns the pins or during a combined enable), the return of both positions to bit 0 on release, the wrap of each position at the chain end, the landing of the first loaded bit, and the reset defaults. Only the bench's scenarios show that whole values arrive in the right bit order and field, that a readback reproduces exactly what was loaded, and that an interrupted readback or load really restarts from the first bit rather than resuming.

// File: rtl/sop_pkg.sv
// Package: shared types for the serial offset programming port.
// Assumes: one action per serial clock edge, decoded from the pin levels.
package sop_pkg;

    // Action taken on a serial clock edge
    typedef enum logic [1:0] {
        SOP_OFF  = 2'd0,   // pins belong to the test port
        SOP_IDLE = 2'd1,   // port owned, no enable asserted
        SOP_LOAD = 2'd2,   // shift one bit into the chain
        SOP_READ = 2'd3    // shift one bit out of the chain
    } sop_act_e;

endpackage

// File: rtl/sop_decode.sv
// Module: sop_decode
// Decodes port select and the two active-low enables into one action and
// the two position-restart requests. Load has priority over readback.
// Assumes: inputs are already synchronous to the serial clock.
module sop_decode
    import sop_pkg::*;
(
    input  logic     port_sel,
    input  logic     wr_en_n,
    input  logic     rd_en_n,
    output sop_act_e act,
    output logic     wr_restart,
    output logic     rd_restart
);

    // Pick the edge action from pin levels
    always_comb begin
        if (port_sel)
            act = SOP_OFF;
        else if (!wr_en_n)
            act = SOP_LOAD;
        else if (!rd_en_n)
            act = SOP_READ;
        else
            act = SOP_IDLE;
    end

    // A released enable sends its position back to the first bit
    always_comb begin
        wr_restart = !port_sel && wr_en_n;
        rd_restart = !port_sel && rd_en_n;
    end

endmodule

// File: rtl/sop_ptr.sv
// Module: sop_ptr
// Bit position counter over a chain of DEPTH bits. Clear wins over advance;
// advance wraps from the last bit to bit 0.
// Assumes: DEPTH >= 2.
module sop_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Hold, clear, or step the position with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/sop_chain.sv
// Module: sop_chain
// Storage for both offsets as one bit chain: low half almost-empty, high
// half almost-full. One bit written per enabled edge at the write
// position; the bit at the read position is offered combinationally.
// Assumes: positions never exceed 2*OFFSET_W-1.
module sop_chain #(
    parameter int OFFSET_W = 8,
    parameter logic [OFFSET_W-1:0] EMPTY_DEFAULT = 7,
    parameter logic [OFFSET_W-1:0] FULL_DEFAULT  = 7,
    localparam int CHAIN_LEN = 2 * OFFSET_W,
    localparam int PTR_W = $clog2(CHAIN_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [PTR_W-1:0]    wptr,
    input  logic                din,
    input  logic [PTR_W-1:0]    rptr,
    output logic                bit_out,
    output logic [OFFSET_W-1:0] empty_ofs,
    output logic [OFFSET_W-1:0] full_ofs
);

    localparam logic [CHAIN_LEN-1:0] RESET_CHAIN = {FULL_DEFAULT, EMPTY_DEFAULT};

    logic [CHAIN_LEN-1:0] bits;

    // One flop per chain bit, loaded only when the write position selects it
    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[g] <= RESET_CHAIN[g];
            else if (we && (wptr == PTR_W'(g)))
                bits[g] <= din;
        end
    end

    // Offer the addressed bit and split the chain into the two offsets
    always_comb begin
        bit_out   = bits[rptr];
        empty_ofs = bits[OFFSET_W-1:0];
        full_ofs  = bits[CHAIN_LEN-1:OFFSET_W];
    end

endmodule

// File: rtl/sop_serial_port.sv
// Module: sop_serial_port (top)
// Serial load and readback of the almost-empty / almost-full offsets.
// Assumes: sclk is the only clock; all pins are synchronous to it; the
// test port sharing these pins is handled elsewhere.
module sop_serial_port
    import sop_pkg::*;
#(
    parameter int OFFSET_W = 8,
    parameter logic [OFFSET_W-1:0] EMPTY_DEFAULT = 7,
    parameter logic [OFFSET_W-1:0] FULL_DEFAULT  = 7
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                port_sel,
    input  logic                wr_en_n,
    input  logic                rd_en_n,
    input  logic                ser_in,
    output logic                ser_out,
    output logic [OFFSET_W-1:0] empty_ofs,
    output logic [OFFSET_W-1:0] full_ofs
);

    localparam int CHAIN_LEN = 2 * OFFSET_W;
    localparam int PTR_W = $clog2(CHAIN_LEN);

    sop_act_e         act;
    logic             wr_restart;
    logic             rd_restart;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             chain_bit;

    sop_decode u_decode (
        .port_sel   (port_sel),
        .wr_en_n    (wr_en_n),
        .rd_en_n    (rd_en_n),
        .act        (act),
        .wr_restart (wr_restart),
        .rd_restart (rd_restart)
    );

    sop_ptr #(.DEPTH(CHAIN_LEN)) u_wr_ptr (
        .clk   (sclk),
        .rst_n (rst_n),
        .clr   (wr_restart),
        .adv   (act == SOP_LOAD),
        .ptr   (wr_ptr)
    );

    sop_ptr #(.DEPTH(CHAIN_LEN)) u_rd_ptr (
        .clk   (sclk),
        .rst_n (rst_n),
        .clr   (rd_restart),
        .adv   (act == SOP_READ),
        .ptr   (rd_ptr)
    );

    sop_chain #(
        .OFFSET_W      (OFFSET_W),
        .EMPTY_DEFAULT (EMPTY_DEFAULT),
        .FULL_DEFAULT  (FULL_DEFAULT)
    ) u_chain (
        .clk       (sclk),
        .rst_n     (rst_n),
        .we        (act == SOP_LOAD),
        .wptr      (wr_ptr),
        .din       (ser_in),
        .rptr      (rd_ptr),
        .bit_out   (chain_bit),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    // Register the read bit; hold it on every other action
    always_ff @(posedge sclk) begin
        if (!rst_n)
            ser_out <= 1'b0;
        else if (act == SOP_READ)
            ser_out <= chain_bit;
    end

endmodule

// File: rtl/sop_checker.sv
// Module: sop_checker
// Concurrent checks on the serial offset port, attached by bind.
// Assumes: connected to the top's ports and its two position registers.
module sop_checker #(
    parameter int OFFSET_W = 8,
    parameter logic [OFFSET_W-1:0] EMPTY_DEFAULT = 7,
    parameter logic [OFFSET_W-1:0] FULL_DEFAULT  = 7,
    localparam int CHAIN_LEN = 2 * OFFSET_W,
    localparam int PTR_W = $clog2(CHAIN_LEN)
) (
    input logic                sclk,
    input logic                rst_n,
    input logic                port_sel,
    input logic                wr_en_n,
    input logic                rd_en_n,
    input logic                ser_in,
    input logic                ser_out,
    input logic [OFFSET_W-1:0] empty_ofs,
    input logic [OFFSET_W-1:0] full_ofs,
    input logic [PTR_W-1:0]    wr_ptr,
    input logic [PTR_W-1:0]    rd_ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(CHAIN_LEN - 1);

    logic rst_q = 1'b1;
    logic seen_rst = 1'b0;

    // Track reset release for the default-value check
    always_ff @(posedge sclk) begin
        rst_q    <= rst_n;
        seen_rst <= seen_rst || !rst_n;
    end

    assert_reset_defaults_R6: assert property (@(posedge sclk)
        (seen_rst && rst_n && !rst_q) |->
            (empty_ofs == EMPTY_DEFAULT && full_ofs == FULL_DEFAULT &&
             ser_out == 1'b0 && wr_ptr == '0 && rd_ptr == '0));

    assert_first_bit_R1: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && !wr_en_n && wr_ptr == '0) |=> (empty_ofs[0] == $past(ser_in)));

    assert_retain_R2: assert property (@(posedge sclk) disable iff (!rst_n)
        (port_sel || wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_rd_release_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && rd_en_n) |=> (rd_ptr == '0 && $stable(ser_out)));

    assert_test_port_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        port_sel |=> ($stable(ser_out) && $stable(wr_ptr) && $stable(rd_ptr)));

    assert_wr_wrap_R7: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && !wr_en_n && wr_ptr == LAST) |=> (wr_ptr == '0));

    assert_wr_restart_R8: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && wr_en_n) |=> (wr_ptr == '0));

    assert_both_enables_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && !wr_en_n && !rd_en_n) |=> ($stable(ser_out) && $stable(rd_ptr)));

    assert_rd_wrap_R10: assert property (@(posedge sclk) disable iff (!rst_n)
        (!port_sel && wr_en_n && !rd_en_n && rd_ptr == LAST) |=> (rd_ptr == '0));

endmodule

bind sop_serial_port sop_checker #(
    .OFFSET_W      (OFFSET_W),
    .EMPTY_DEFAULT (EMPTY_DEFAULT),
    .FULL_DEFAULT  (FULL_DEFAULT)
) u_sop_checker (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/tb_sop_serial_port.sv
module tb_sop_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 2 * W;
    localparam int NVEC = 4;
    // {empty value, full value}; after a load both must read back unchanged
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {8'h03, 8'hC0}, {8'hFF, 8'h00}, {8'hA5, 8'h5A}, {8'h01, 8'h80}
    };

    logic         sclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         port_sel = 1'b0;
    logic         wr_en_n = 1'b1;
    logic         rd_en_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic [W-1:0] empty_ofs;
    logic [W-1:0] full_ofs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) sclk = ~sclk;

    sop_serial_port #(.OFFSET_W(W)) dut (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .port_sel  (port_sel),
        .wr_en_n   (wr_en_n),
        .rd_en_n   (rd_en_n),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at a falling edge, pass one rising edge, return at the next falling edge
    task automatic tick(input logic sel, input logic wn, input logic rn, input logic si);
        port_sel = sel; wr_en_n = wn; rd_en_n = rn; ser_in = si;
        @(posedge sclk);
        @(negedge sclk);
    endtask

    // Full load of both offsets, then release of the write enable
    task automatic load_pair(input logic [W-1:0] e, input logic [W-1:0] f);
        logic [N-1:0] chain;
        chain = {f, e};
        for (int i = 0; i < N; i++) tick(1'b0, 1'b0, 1'b1, chain[i]);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge sclk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] ch;
        logic         held;
        repeat (3) @(posedge sclk);
        @(negedge sclk);
        rst_n = 1'b1;

        // R6: defaults after reset
        check("R6 empty default", 32'(empty_ofs), 32'd7);
        check("R6 full default", 32'(full_ofs), 32'd7);
        check("R6 ser_out reset", 32'(ser_out), 32'd0);

        // R6/R3: readback of reset chain, first two bits of 7 are 1
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 read bit0 of default", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);

        // Vector table: R1 load layout, R3 readback order, R4 hold on release
        for (int v = 0; v < NVEC; v++) begin
            ch = {VEC[v][W-1:0], VEC[v][2*W-1:W]};
            load_pair(VEC[v][2*W-1:W], VEC[v][W-1:0]);
            check("R1 empty value", 32'(empty_ofs), 32'(VEC[v][2*W-1:W]));
            check("R1 full value", 32'(full_ofs), 32'(VEC[v][W-1:0]));
            for (int i = 0; i < N; i++) begin
                tick(1'b0, 1'b1, 1'b0, 1'b0);
                check("R3 readback bit", 32'(ser_out), 32'(ch[i]));
            end
            tick(1'b0, 1'b1, 1'b1, 1'b0);
            check("R4 ser_out holds on release", 32'(ser_out), 32'(ch[N-1]));
        end
        // chain now holds empty=01, full=80

        // R2: ser_in toggling with write enable high changes nothing
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1, 1'(i));
        check("R2 empty retained", 32'(empty_ofs), 32'h01);
        check("R2 full retained", 32'(full_ofs), 32'h80);

        // R4: partial read, release, read restarts at bit 0
        load_pair(8'hB6, 8'h00);                // bits: 0,1,1,0,...
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R3 partial read bit2", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 restart at bit0", 32'(ser_out), 32'd0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 restart then bit1", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);

        // R5: test port owns pins: no load, no read
        held = ser_out;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b1, 1'b1);
        check("R5 no load empty", 32'(empty_ofs), 32'hB6);
        check("R5 no load full", 32'(full_ofs), 32'h00);
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 no read", 32'(ser_out), 32'(held));

        // R7: load of N+3 bits wraps onto bits 0..2
        for (int i = 0; i < N; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 wrapped load empty", 32'(empty_ofs), 32'h07);
        check("R7 wrapped load full", 32'(full_ofs), 32'h00);

        // R8: two short loads each start at bit 0
        for (int i = 0; i < 2; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b1, 1'b1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 load restarts at bit0", 32'(empty_ofs), 32'h05);

        // R10: read N+2 bits, last two repeat bits 0 and 1 (chain empty=05 full=00)
        for (int i = 0; i < N; i++) tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 last chain bit", 32'(ser_out), 32'd0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 wrap to bit0", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 wrap to bit1", 32'(ser_out), 32'd0);

        // R9: both enables: load only, ser_out and read position hold
        tick(1'b0, 1'b1, 1'b0, 1'b0);           // read position now at bit 3, ser_out=bit2=1
        check("R9 setup bit2", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);           // release read; write position already 0
        tick(1'b0, 1'b1, 1'b0, 1'b0);           // ser_out = bit0 = 1, read pos 1
        tick(1'b0, 1'b0, 1'b0, 1'b0);           // load bit0 = 0, read held
        check("R9 ser_out holds", 32'(ser_out), 32'd1);
        check("R9 load applied", 32'(empty_ofs), 32'h04);
        tick(1'b0, 1'b1, 1'b0, 1'b0);           // read resumes at bit1 = 0
        tick(1'b0, 1'b1, 1'b0, 1'b0);           // bit2 = 1
        check("R9 read position held", 32'(ser_out), 32'd1);
        tick(1'b0, 1'b1, 1'b1, 1'b0);

        // R6: reset mid-operation restores defaults
        rst_n = 1'b0;
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        check("R6 empty after reset", 32'(empty_ofs), 32'd7);
        check("R6 full after reset", 32'(full_ofs), 32'd7);
        check("R6 ser_out after reset", 32'(ser_out), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule